// File: doc/BRIEF.md
# Idle-Fired Frequency Switch Handshake

This block is a per-core controller for a dynamic clock-frequency change. Software arms a change by setting a request bit. The controller does nothing until the core itself goes idle. The switch fires only when the core asserts its wait-for-interrupt indication, the idle-wait enable is set and both interrupt kinds are masked. At that point the controller sends one request pulse to an external clock-switching unit and then waits for that unit's acknowledge.

On acknowledge, the controller does three things. It clears the armed request bit, sets a sticky done event and sends a one-cycle wake pulse to the core. Software can poll the done event with its interrupt masked. It can also unmask the event and take the interrupt output instead. Software removes a stale done event by writing its bit as 0 before it arms the next change.

The per-core register view has three words. Their byte offsets are parameters, with defaults 0x04 (control), 0x0C (status) and 0x20 (event). Bit positions inside each word are fixed, as the requirements state.

Top module: `dfs_idle_switch`

## Requirements
- R1: After synchronous reset, all register bits, `clk_sw_req`, `core_wake` and `irq_out` are 0, and every register reads 0.
- R2: Register access works as follows:
  - The control word holds the request-arm bit at bit 18.
  - The status word holds the idle-wait enable at bit 16, the IRQ mask at bit 24 and the FIQ mask at bit 25.
  - The event word holds the done event at bit 1 and the done-interrupt mask at bit 17.
  - Writable bits read back as written. All other bits read 0.
  - `reg_rdata` shows the word addressed by `reg_addr` one clock later.
- R3: `clk_sw_req` is high for exactly one cycle. It goes high in the cycle after a clock edge at which all of the following hold: the controller is idle, the request bit is armed, `core_wfi` is high, idle-wait is enabled, and the IRQ and FIQ masks are both set.
- R4: If any one of `core_wfi`, idle-wait, IRQ mask or FIQ mask is low, no request pulse is issued, even when the request bit is armed.
- R5: Only one request pulse is issued per armed request. While the controller waits for acknowledge, no further pulse appears.
- R6: An acknowledge taken while waiting does three things at the same clock edge: it clears the request bit, sets the done bit and drives `core_wake` high for exactly one cycle.
- R7: The done bit is sticky:
  - Writing the event word with bit 1 = 1 does not set it.
  - Writing bit 1 = 0 clears it.
  - If the acknowledge arrives in the same cycle as a clearing write, the done bit ends up set.
- R8: `irq_out` equals done AND NOT mask, registered so that it changes in the same cycle as the bits it is built from.
- R9: If the request bit is written back to 0 before the core enters WFI, no transition starts and the done bit stays 0.
- R10: A `clk_sw_ack` that arrives while the controller is not waiting is ignored: done stays 0 and no wake pulse is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte offset in the per-core view |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Registered read data of the addressed word |
| core_wfi | input | 1 | Core is in wait-for-interrupt |
| core_wake | output | 1 | One-cycle wake pulse to the core |
| clk_sw_req | output | 1 | One-cycle request to the clock-switching unit |
| clk_sw_ack | input | 1 | Acknowledge from the clock-switching unit |
| irq_out | output | 1 | Done interrupt |

## Verification
The bench sweeps all sixteen combinations of WFI, idle-wait and the two masks with the request armed. A design that ignored one gating term would fire on a combination the sweep treats as forbidden. It also counts request pulses across a long wait, which catches a controller that re-fires every cycle while the core stays in WFI.

The sticky done bit is tested three ways: against a write of 1, against a write of 0, and against a clearing write that lands in the same cycle as the acknowledge. A controller with the wrong priority would lose that completion. Stray acknowledges while idle, and a request cancelled before WFI, must both leave done at 0. A design that latched the acknowledge unconditionally would show a spurious event.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  localparam int CTRL_REQ_BIT  = 18;
  localparam int STAT_IDLE_BIT = 16;
  localparam int STAT_IRQM_BIT = 24;
  localparam int STAT_FIQM_BIT = 25;
  localparam int EVT_DONE_BIT  = 1;
  localparam int EVT_MASK_BIT  = 17;

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_WAIT = 1'b1} seq_state_t;
endpackage

// File: rtl/dfs_regs.sv
module dfs_regs
  import dfs_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] OFS_CTRL = 8'h04,
  parameter logic [AW-1:0] OFS_STAT = 8'h0C,
  parameter logic [AW-1:0] OFS_EVT  = 8'h20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          hw_req_clr,
  input  logic          hw_done_set,
  output logic          req_bit,
  output logic          idle_wait,
  output logic          mask_irq,
  output logic          mask_fiq,
  output logic          done_bit,
  output logic          done_mask,
  output logic          irq_q,
  output logic [DW-1:0] rdata
);
  logic wr_ctrl, wr_stat, wr_evt;
  logic req_n, idle_n, irqm_n, fiqm_n, done_n, mask_n;
  logic [DW-1:0] rd_n;
  logic unused_wbits;

  assign unused_wbits = ^wdata;
  assign wr_ctrl = we && (addr == OFS_CTRL);
  assign wr_stat = we && (addr == OFS_STAT);
  assign wr_evt  = we && (addr == OFS_EVT);

  always_comb begin
    req_n  = req_bit;
    idle_n = idle_wait;
    irqm_n = mask_irq;
    fiqm_n = mask_fiq;
    done_n = done_bit;
    mask_n = done_mask;
    if (wr_ctrl) req_n = wdata[CTRL_REQ_BIT];
    if (hw_req_clr) req_n = 1'b0;
    if (wr_stat) begin
      idle_n = wdata[STAT_IDLE_BIT];
      irqm_n = wdata[STAT_IRQM_BIT];
      fiqm_n = wdata[STAT_FIQM_BIT];
    end
    if (wr_evt) begin
      mask_n = wdata[EVT_MASK_BIT];
      if (!wdata[EVT_DONE_BIT]) done_n = 1'b0;
    end
    if (hw_done_set) done_n = 1'b1;
  end

  always_comb begin
    rd_n = '0;
    if (addr == OFS_CTRL) begin
      rd_n[CTRL_REQ_BIT] = req_bit;
    end else if (addr == OFS_STAT) begin
      rd_n[STAT_IDLE_BIT] = idle_wait;
      rd_n[STAT_IRQM_BIT] = mask_irq;
      rd_n[STAT_FIQM_BIT] = mask_fiq;
    end else if (addr == OFS_EVT) begin
      rd_n[EVT_DONE_BIT] = done_bit;
      rd_n[EVT_MASK_BIT] = done_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_bit   <= 1'b0;
      idle_wait <= 1'b0;
      mask_irq  <= 1'b0;
      mask_fiq  <= 1'b0;
      done_bit  <= 1'b0;
      done_mask <= 1'b0;
      irq_q     <= 1'b0;
      rdata     <= '0;
    end else begin
      req_bit   <= req_n;
      idle_wait <= idle_n;
      mask_irq  <= irqm_n;
      mask_fiq  <= fiqm_n;
      done_bit  <= done_n;
      done_mask <= mask_n;
      irq_q     <= done_n & ~mask_n;
      rdata     <= rd_n;
    end
  end
endmodule

// File: rtl/dfs_seq.sv
module dfs_seq
  import dfs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_bit,
  input  logic idle_wait,
  input  logic mask_irq,
  input  logic mask_fiq,
  input  logic core_wfi,
  input  logic ack_in,
  output logic sw_req,
  output logic wake,
  output logic busy,
  output logic ack_take
);
  seq_state_t state;
  logic fire;

  assign busy     = (state == SEQ_WAIT);
  assign fire     = (state == SEQ_IDLE) && req_bit && core_wfi &&
                    idle_wait && mask_irq && mask_fiq;
  assign ack_take = busy && ack_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SEQ_IDLE;
      sw_req <= 1'b0;
      wake   <= 1'b0;
    end else begin
      sw_req <= fire;
      wake   <= ack_take;
      if (fire)          state <= SEQ_WAIT;
      else if (ack_take) state <= SEQ_IDLE;
    end
  end
endmodule

// File: rtl/dfs_idle_switch.sv
module dfs_idle_switch #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] OFS_CTRL = 8'h04,
  parameter logic [AW-1:0] OFS_STAT = 8'h0C,
  parameter logic [AW-1:0] OFS_EVT  = 8'h20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          core_wfi,
  output logic          core_wake,
  output logic          clk_sw_req,
  input  logic          clk_sw_ack,
  output logic          irq_out
);
  logic req_bit, idle_wait, mask_irq, mask_fiq, done_bit, done_mask;
  logic busy, ack_take;

  dfs_regs #(.AW(AW), .DW(DW), .OFS_CTRL(OFS_CTRL), .OFS_STAT(OFS_STAT),
             .OFS_EVT(OFS_EVT)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .hw_req_clr(ack_take), .hw_done_set(ack_take),
    .req_bit(req_bit), .idle_wait(idle_wait), .mask_irq(mask_irq),
    .mask_fiq(mask_fiq), .done_bit(done_bit), .done_mask(done_mask),
    .irq_q(irq_out), .rdata(reg_rdata)
  );

  dfs_seq u_seq (
    .clk(clk), .rst(rst), .req_bit(req_bit), .idle_wait(idle_wait),
    .mask_irq(mask_irq), .mask_fiq(mask_fiq), .core_wfi(core_wfi),
    .ack_in(clk_sw_ack), .sw_req(clk_sw_req), .wake(core_wake),
    .busy(busy), .ack_take(ack_take)
  );
endmodule

// File: rtl/dfs_idle_switch_chk.sv
module dfs_idle_switch_chk #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] OFS_EVT = 8'h20
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          core_wfi,
  input logic          core_wake,
  input logic          clk_sw_req,
  input logic          irq_out,
  input logic          req_bit,
  input logic          idle_wait,
  input logic          mask_irq,
  input logic          mask_fiq,
  input logic          done_bit,
  input logic          done_mask,
  input logic          busy
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    clk_sw_req |=> !clk_sw_req); // R3
  AST_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
    clk_sw_req |-> $past(core_wfi && req_bit && idle_wait && mask_irq && mask_fiq)); // R4
  AST_NO_REQ_WHILE_WAIT: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> !clk_sw_req); // R5
  AST_WAKE_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    core_wake |-> (done_bit && !req_bit)); // R6
  AST_DONE_RISE_WAKES: assert property (@(posedge clk) disable iff (rst)
    $rose(done_bit) |-> core_wake); // R6
  AST_DONE_FALL_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(done_bit) |-> $past(reg_we && (reg_addr == OFS_EVT) && !reg_wdata[1])); // R7
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_out == (done_bit && !done_mask)); // R8
endmodule

bind dfs_idle_switch dfs_idle_switch_chk #(.AW(AW), .DW(DW), .OFS_EVT(OFS_EVT)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .core_wfi(core_wfi), .core_wake(core_wake),
  .clk_sw_req(clk_sw_req), .irq_out(irq_out), .req_bit(req_bit),
  .idle_wait(idle_wait), .mask_irq(mask_irq), .mask_fiq(mask_fiq),
  .done_bit(done_bit), .done_mask(done_mask), .busy(busy)
);

// File: tb/tb_dfs_idle_switch.sv
`timescale 1ns/1ps
module tb_dfs_idle_switch;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_CTRL = 8'h04;
  localparam logic [AW-1:0] A_STAT = 8'h0C;
  localparam logic [AW-1:0] A_EVT  = 8'h20;
  localparam logic [DW-1:0] REQ  = 32'h1 << 18;
  localparam logic [DW-1:0] IDLE = 32'h1 << 16;
  localparam logic [DW-1:0] IRQM = 32'h1 << 24;
  localparam logic [DW-1:0] FIQM = 32'h1 << 25;
  localparam logic [DW-1:0] DONE = 32'h1 << 1;
  localparam logic [DW-1:0] DMSK = 32'h1 << 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic core_wfi = 1'b0;
  logic core_wake, clk_sw_req, irq_out;
  logic clk_sw_ack = 1'b0;

  int checks = 0;
  int fails = 0;
  int nreq = 0;
  int nwake = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dfs_idle_switch #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_wfi(core_wfi),
    .core_wake(core_wake), .clk_sw_req(clk_sw_req), .clk_sw_ack(clk_sw_ack),
    .irq_out(irq_out)
  );

  always begin
    @(negedge clk);
    #1;
    if (!rst && clk_sw_req) nreq++;
    if (!rst && core_wake) nwake++;
  end

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic ack_once;
    @(negedge clk);
    clk_sw_ack = 1'b1;
    @(negedge clk);
    clk_sw_ack = 1'b0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(!clk_sw_req && !core_wake && !irq_out, "R1 outputs",
          {clk_sw_req, core_wake, irq_out}, 0);
    rd(A_CTRL, v); check(v == 0, "R1 ctrl", v, 0);
    rd(A_STAT, v); check(v == 0, "R1 stat", v, 0);
    rd(A_EVT, v);  check(v == 0, "R1 evt", v, 0);

    // R2: readback of writable bits only
    wr(A_CTRL, '1); rd(A_CTRL, v); check(v == REQ, "R2 ctrl", v, REQ);
    wr(A_CTRL, '0);
    wr(A_STAT, '1); rd(A_STAT, v);
    check(v == (IDLE | IRQM | FIQM), "R2 stat", v, IDLE | IRQM | FIQM);
    wr(A_EVT, '1); rd(A_EVT, v);
    check(v == DMSK, "R2/R7 evt write 1 no set", v, DMSK);
    wr(A_EVT, '0); wr(A_STAT, '0);

    // R3/R4/R5/R6: sweep of gating terms with request armed
    for (int c = 0; c < 16; c++) begin
      logic [DW-1:0] sv;
      sv = (c[1] ? IDLE : 0) | (c[2] ? IRQM : 0) | (c[3] ? FIQM : 0);
      wr(A_STAT, sv);
      wr(A_CTRL, REQ);
      nreq = 0; nwake = 0;
      core_wfi = c[0];
      @(negedge clk); #2;
      if (c == 15) begin
        check(clk_sw_req == 1'b1, "R3 pulse timing", clk_sw_req, 1);
        repeat (6) @(negedge clk); #2;
        check(nreq == 1, "R5 single pulse", nreq, 1);
        ack_once(); #2;
        check(core_wake && irq_out, "R6/R8 wake+irq", {core_wake, irq_out}, 3);
        repeat (3) @(negedge clk); #2;
        check(nwake == 1, "R6 one wake", nwake, 1);
        rd(A_CTRL, v); check(v == 0, "R6 req self-clear", v, 0);
        rd(A_EVT, v);  check(v == DONE, "R6 done set", v, DONE);
        check(nreq == 1, "R5 no refire", nreq, 1);
        core_wfi = 1'b0;
        wr(A_STAT, 0);
        wr(A_EVT, 0);
        rd(A_EVT, v); check(v == 0, "R7 clear by 0", v, 0);
      end else begin
        repeat (4) @(negedge clk); #2;
        check(nreq == 0, $sformatf("R4 gated combo %0d", c), nreq, 0);
        core_wfi = 1'b0;
        wr(A_CTRL, 0);
        rd(A_EVT, v); check(v == 0, "R4 no done", v, 0);
      end
    end

    // R9: cancel before WFI
    wr(A_STAT, IDLE | IRQM | FIQM);
    wr(A_CTRL, REQ);
    wr(A_CTRL, 0);
    nreq = 0;
    core_wfi = 1'b1;
    repeat (5) @(negedge clk); #2;
    check(nreq == 0, "R9 cancelled no pulse", nreq, 0);
    rd(A_EVT, v); check(v == 0, "R9 no done", v, 0);

    // R10: stray acknowledge while idle
    nwake = 0;
    ack_once();
    repeat (2) @(negedge clk); #2;
    check(nwake == 0, "R10 no wake", nwake, 0);
    rd(A_EVT, v); check(v == 0, "R10 done stays 0", v, 0);

    // R8: masked completion, then unmask; R7: ack beats clear
    wr(A_EVT, DMSK);
    nreq = 0;
    wr(A_CTRL, REQ);
    repeat (3) @(negedge clk); #2;
    check(nreq == 1, "R3 fire with wfi held", nreq, 1);
    @(negedge clk);
    clk_sw_ack = 1'b1; reg_we = 1'b1; reg_addr = A_EVT; reg_wdata = DMSK;
    @(negedge clk);
    clk_sw_ack = 1'b0; reg_we = 1'b0; #2;
    check(irq_out == 1'b0, "R8 masked irq low", irq_out, 0);
    rd(A_EVT, v);
    check(v == (DONE | DMSK), "R7 ack beats clear", v, DONE | DMSK);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = A_EVT; reg_wdata = DONE;
    @(negedge clk);
    reg_we = 1'b0; #2;
    check(irq_out == 1'b1, "R8 unmask irq high", irq_out, 1);
    wr(A_EVT, 0); #2;
    check(irq_out == 1'b0, "R8 irq low after clear", irq_out, 0);
    core_wfi = 1'b0;

    finish_run();
  end
endmodule